// File: doc/BRIEF.md
# Common Result Bus Priority Arbiter

This block sits between a set of completing execution sources and the single common data bus that broadcasts finished results to waiting consumers. Each source raises a request while it holds a finished result. With the request it presents an operation-kind code, a destination tag and the result value. Every cycle the arbiter picks exactly one requester and grants it.

The winner is chosen by a fixed ranking of operation kinds. Loads rank highest, then stores, divides, multiplies and subtracts, with adds lowest. When two sources present the same kind, the lower-numbered source wins. The grant is combinational, so the winning source sees it in the same cycle and drops its request at the next edge. A losing source keeps its request raised and competes again on every following cycle.

The granted tag and value are captured on the clock edge that ends the grant cycle. They are driven on the bus, together with a valid strobe, for exactly the one following cycle.

Top module: `cdb_result_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle.
- R2: A `grant` bit is high only for a source whose `req_valid` bit is high, and whenever any `req_valid` bit is high some `grant` bit is high.
- R3: Operation codes on `req_op` (3 bits per source, source i at bits 3i+2..3i) are 5 load, 4 store, 3 divide, 2 multiply, 1 subtract and 0 add. The grant goes to a requesting source with the highest code.
- R4: Among requesting sources that share the highest code, the one with the lowest index is granted.
- R5: In the cycle after a grant, `bus_valid` is high and `bus_tag`/`bus_value` carry the tag and value that the granted source presented during the grant cycle. Each grant yields exactly one cycle of bus valid.
- R6: In a cycle with no request, `grant` is all zero. In the following cycle `bus_valid` is low and `bus_tag` and `bus_value` are zero (zero is the null tag).
- R7: While and after synchronous reset `rst` is high, `bus_valid`, `bus_tag` and `bus_value` are zero until the first grant after reset.
- R8: A request that loses arbitration and is held high is granted in a later cycle once no request of higher rank (or of equal rank from a lower index) remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_SRC | Per-source completion request, held until granted |
| req_op | input | N_SRC*3 | Per-source operation code, source i at bits 3i+2..3i |
| req_tag | input | N_SRC*TAG_W | Per-source destination tag |
| req_value | input | N_SRC*DATA_W | Per-source result value |
| grant | output | N_SRC | One-hot grant for the current cycle |
| bus_valid | output | 1 | Bus carries a result this cycle |
| bus_tag | output | TAG_W | Tag of the broadcast result, zero when idle |
| bus_value | output | DATA_W | Value of the broadcast result, zero when idle |

## Verification
The assertions take for granted that every operation code lies in the range 0 to 5. They also take for granted that request, code, tag and value inputs change only between clock edges, so that the properties comparing the bus against the previous cycle's grant see stable data. The stimulus drives only the six defined codes and updates every input on the falling clock edge. In the retry sequences it clears a source's request only after that source has been granted, as a real completing unit would.

// File: rtl/cdb_arb_pkg.sv
package cdb_arb_pkg;

    localparam int OP_W = 3;

    // Operation kinds; the numeric code doubles as the priority rank.
    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_MUL   = 3'd2,
        OP_DIV   = 3'd3,
        OP_STORE = 3'd4,
        OP_LOAD  = 3'd5
    } op_kind_e;

    // Rank of an operation code; undefined codes fall to the lowest rank.
    function automatic logic [OP_W-1:0] op_rank(input logic [OP_W-1:0] code);
        return (code > OP_LOAD) ? OP_ADD : code;
    endfunction

endpackage

// File: rtl/cdb_rank_pick.sv
module cdb_rank_pick
    import cdb_arb_pkg::*;
#(
    parameter int N_SRC = 6,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]      req_valid,
    input  logic [N_SRC*OP_W-1:0] req_op,
    output logic [N_SRC-1:0]      grant,
    output logic                  win_any,
    output logic [IDX_W-1:0]      win_idx
);

    logic [OP_W-1:0] rank [N_SRC];

    for (genvar g = 0; g < N_SRC; g++) begin : g_rank
        assign rank[g] = op_rank(req_op[g*OP_W +: OP_W]);
    end

    // Scan from the highest index down; ">=" lets a lower index take ties.
    always_comb begin
        logic [OP_W-1:0] best;
        best    = '0;
        win_any = 1'b0;
        win_idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_valid[i] && (!win_any || rank[i] >= best)) begin
                win_any = 1'b1;
                best    = rank[i];
                win_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        grant = '0;
        if (win_any) begin
            grant[win_idx] = 1'b1;
        end
    end

endmodule

// File: rtl/cdb_bus_stage.sv
module cdb_bus_stage #(
    parameter int N_SRC  = 6,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     win_any,
    input  logic [IDX_W-1:0]         win_idx,
    input  logic [N_SRC*TAG_W-1:0]   req_tag,
    input  logic [N_SRC*DATA_W-1:0]  req_value,
    output logic                     bus_valid,
    output logic [TAG_W-1:0]         bus_tag,
    output logic [DATA_W-1:0]        bus_value
);

    logic [TAG_W-1:0]  sel_tag;
    logic [DATA_W-1:0] sel_value;

    always_comb begin
        sel_tag   = '0;
        sel_value = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (win_any && win_idx == IDX_W'(i)) begin
                sel_tag   = req_tag[i*TAG_W +: TAG_W];
                sel_value = req_value[i*DATA_W +: DATA_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_valid <= 1'b0;
            bus_tag   <= '0;
            bus_value <= '0;
        end else begin
            bus_valid <= win_any;
            bus_tag   <= sel_tag;
            bus_value <= sel_value;
        end
    end

endmodule

// File: rtl/cdb_result_arbiter.sv
module cdb_result_arbiter
    import cdb_arb_pkg::*;
#(
    parameter int N_SRC  = 6,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N_SRC-1:0]         req_valid,
    input  logic [N_SRC*OP_W-1:0]    req_op,
    input  logic [N_SRC*TAG_W-1:0]   req_tag,
    input  logic [N_SRC*DATA_W-1:0]  req_value,
    output logic [N_SRC-1:0]         grant,
    output logic                     bus_valid,
    output logic [TAG_W-1:0]         bus_tag,
    output logic [DATA_W-1:0]        bus_value
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic             win_any;
    logic [IDX_W-1:0] win_idx;

    cdb_rank_pick #(.N_SRC(N_SRC)) pick_i (
        .req_valid (req_valid),
        .req_op    (req_op),
        .grant     (grant),
        .win_any   (win_any),
        .win_idx   (win_idx)
    );

    cdb_bus_stage #(.N_SRC(N_SRC), .TAG_W(TAG_W), .DATA_W(DATA_W)) bus_i (
        .clk       (clk),
        .rst       (rst),
        .win_any   (win_any),
        .win_idx   (win_idx),
        .req_tag   (req_tag),
        .req_value (req_value),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_value (bus_value)
    );

endmodule

// File: rtl/cdb_result_arbiter_chk.sv
module cdb_result_arbiter_chk
    import cdb_arb_pkg::*;
#(
    parameter int N_SRC  = 6,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic [N_SRC-1:0]         req_valid,
    input logic [N_SRC*OP_W-1:0]    req_op,
    input logic [N_SRC*TAG_W-1:0]   req_tag,
    input logic [N_SRC*DATA_W-1:0]  req_value,
    input logic [N_SRC-1:0]         grant,
    input logic                     bus_valid,
    input logic [TAG_W-1:0]         bus_tag,
    input logic [DATA_W-1:0]        bus_value
);

    logic              rank_bad;
    logic              tie_bad;
    logic [TAG_W-1:0]  g_tag;
    logic [DATA_W-1:0] g_val;

    // Pairwise view: a granted source must not be outranked by any requester.
    always_comb begin
        rank_bad = 1'b0;
        tie_bad  = 1'b0;
        g_tag    = '0;
        g_val    = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (grant[i]) begin
                g_tag = req_tag[i*TAG_W +: TAG_W];
                g_val = req_value[i*DATA_W +: DATA_W];
                for (int j = 0; j < N_SRC; j++) begin
                    if (req_valid[j] && req_op[j*OP_W +: OP_W] > req_op[i*OP_W +: OP_W])
                        rank_bad = 1'b1;
                    if (req_valid[j] && j < i && req_op[j*OP_W +: OP_W] == req_op[i*OP_W +: OP_W])
                        tie_bad = 1'b1;
                end
            end
        end
    end

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req_valid) == '0);

    assert_work_conserving_R2: assert property (@(posedge clk) disable iff (rst)
        (|req_valid) |-> (|grant));

    assert_rank_order_R3: assert property (@(posedge clk) disable iff (rst)
        !rank_bad);

    assert_low_index_tie_R4: assert property (@(posedge clk) disable iff (rst)
        !tie_bad);

    assert_bus_carries_grant_R5: assert property (@(posedge clk) disable iff (rst)
        (|grant) |=> (bus_valid && bus_tag == $past(g_tag) && bus_value == $past(g_val)));

    assert_idle_null_R6: assert property (@(posedge clk) disable iff (rst)
        !(|grant) |=> (!bus_valid && bus_tag == '0 && bus_value == '0));

endmodule

bind cdb_result_arbiter cdb_result_arbiter_chk #(
    .N_SRC(N_SRC), .TAG_W(TAG_W), .DATA_W(DATA_W)
) chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_tag(req_tag), .req_value(req_value), .grant(grant),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value)
);

// File: tb/cdb_result_arbiter_tb_top.sv
`timescale 1ns/1ps
module cdb_result_arbiter_tb_top;

    localparam int N      = 6;
    localparam int TAG_W  = 4;
    localparam int DATA_W = 16;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [N-1:0]         req_valid = '0;
    logic [N*3-1:0]       req_op = '0;
    logic [N*TAG_W-1:0]   req_tag;
    logic [N*DATA_W-1:0]  req_value;
    logic [N-1:0]         grant;
    logic                 bus_valid;
    logic [TAG_W-1:0]     bus_tag;
    logic [DATA_W-1:0]    bus_value;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cdb_result_arbiter #(.N_SRC(N), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_tag(req_tag), .req_value(req_value), .grant(grant),
        .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_value(bus_value)
    );

    // Source i: tag i+1, value 0xC000 + 0x111*i.
    for (genvar g = 0; g < N; g++) begin : g_src
        assign req_tag[g*TAG_W +: TAG_W]    = TAG_W'(g + 1);
        assign req_value[g*DATA_W +: DATA_W] = DATA_W'(16'hC000 + 16'h0111 * g);
    end

    typedef struct packed {
        logic [5:0] rv;
        logic [2:0] o5, o4, o3, o2, o1, o0;
        logic [5:0] eg;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{6'b000001, 3'd0,3'd0,3'd0,3'd0,3'd0,3'd5, 6'b000001}, // R2 lone load
        '{6'b000101, 3'd0,3'd0,3'd0,3'd0,3'd0,3'd5, 6'b000001}, // R3 load beats add
        '{6'b000110, 3'd0,3'd0,3'd0,3'd0,3'd4,3'd0, 6'b000010}, // R3 store beats add
        '{6'b111000, 3'd3,3'd2,3'd1,3'd0,3'd0,3'd0, 6'b100000}, // R3 div > mul > sub
        '{6'b011000, 3'd0,3'd2,3'd1,3'd0,3'd0,3'd0, 6'b010000}, // R3 mul beats sub
        '{6'b001100, 3'd0,3'd0,3'd0,3'd0,3'd0,3'd0, 6'b000100}, // R4 two adds
        '{6'b111111, 3'd5,3'd0,3'd1,3'd2,3'd3,3'd4, 6'b100000}, // R3 load at top index
        '{6'b011111, 3'd5,3'd0,3'd1,3'd2,3'd3,3'd4, 6'b000001}, // R3 store next
        '{6'b110000, 3'd2,3'd2,3'd0,3'd0,3'd0,3'd0, 6'b010000}, // R4 two muls
        '{6'b000000, 3'd0,3'd0,3'd0,3'd0,3'd0,3'd0, 6'b000000}, // R6 idle
        '{6'b100001, 3'd1,3'd0,3'd0,3'd0,3'd0,3'd0, 6'b100000}, // R3 sub beats add
        '{6'b010010, 3'd0,3'd5,3'd0,3'd0,3'd5,3'd0, 6'b000010}  // R4 two loads
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [5:0] oh);
        for (int i = 0; i < N; i++) if (oh[i]) return i;
        return -1;
    endfunction

    task automatic check_bus(input string req, input logic [5:0] eg);
        int k;
        k = idx_of(eg);
        if (k < 0) begin
            check({req, " bus_valid"}, 32'(bus_valid), 32'd0);
            check({req, " bus_tag"},   32'(bus_tag),   32'd0);
            check({req, " bus_value"}, 32'(bus_value), 32'd0);
        end else begin
            check({req, " bus_valid"}, 32'(bus_valid), 32'd1);
            check({req, " bus_tag"},   32'(bus_tag),   32'(k + 1));
            check({req, " bus_value"}, 32'(bus_value), 32'(16'hC000 + 16'h0111 * k));
        end
    endtask

    initial begin
        #(20 * 5000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R7: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R7 bus_valid in reset", 32'(bus_valid), 32'd0);
        check("R7 bus_tag in reset",   32'(bus_tag),   32'd0);
        check("R7 bus_value in reset", 32'(bus_value), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R7 bus_valid after reset", 32'(bus_valid), 32'd0);

        // Vector table: R1..R6
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            req_valid = VEC[v].rv;
            req_op = {VEC[v].o5, VEC[v].o4, VEC[v].o3, VEC[v].o2, VEC[v].o1, VEC[v].o0};
            #1;
            check($sformatf("R1 R2 R3 R4 grant vec%0d", v), 32'(grant), 32'(VEC[v].eg));
            @(posedge clk);
            #1;
            check_bus($sformatf("R5 R6 vec%0d", v), VEC[v].eg);
        end

        // R8: held losers retried; sources drop a request only once granted.
        // src0 load, src2 add, src3 sub, src5 add -> order 0, 3, 2, 5, idle.
        begin
            logic [5:0] order [5];
            order[0] = 6'b000001; order[1] = 6'b001000; order[2] = 6'b000100;
            order[3] = 6'b100000; order[4] = 6'b000000;
            @(negedge clk);
            req_valid = 6'b101101;
            req_op = {3'd0, 3'd0, 3'd1, 3'd0, 3'd0, 3'd5};
            for (int s = 0; s < 5; s++) begin
                #1;
                check($sformatf("R8 retry grant step%0d", s), 32'(grant), 32'(order[s]));
                @(posedge clk);
                #1;
                check_bus($sformatf("R5 R8 retry step%0d", s), order[s]);
                @(negedge clk);
                req_valid = req_valid & ~order[s];
            end
        end

        // R5: a single grant gives exactly one valid cycle
        req_valid = 6'b010000;
        req_op = {3'd0, 3'd3, 3'd0, 3'd0, 3'd0, 3'd0};
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        #1;
        check("R5 valid during pulse", 32'(bus_valid), 32'd1);
        @(posedge clk);
        #1;
        check("R5 valid after pulse", 32'(bus_valid), 32'd0);

        // R7: reset mid-stream clears the bus
        @(negedge clk);
        req_valid = 6'b000011;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R7 reset clears valid", 32'(bus_valid), 32'd0);
        check("R7 reset clears tag",   32'(bus_tag),   32'd0);
        @(negedge clk);
        rst = 1'b0;
        req_valid = '0;
        @(posedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule